// File: doc/BRIEF.md
# DMA Channel Command Sequencer

This block sequences one DMA channel. After a kick from idle it reads a three-word command descriptor from memory, then moves 32-bit words between a memory buffer and a peripheral, one word per peripheral data request. When the descriptor's byte count is used up, it can wait for the peripheral to report command end, wait for an external device to report ready, raise an interrupt pulse, and follow a chain pointer to the next descriptor or go back to idle.

Memory is reached through a request/grant master port. A request, with its address, write flag and write data, stays asserted until a grant arrives. Read data is valid in the grant cycle. A granted write is not complete until a separate done strobe arrives. A terminate input stops the channel, but only after the memory access already in flight has finished. If halt-on-terminate is set, the channel then parks in a halt state, and only a channel reset releases it. A read-only debug word shows the bytes still to move on the memory side and on the peripheral side.

Descriptor layout, as byte offsets from the descriptor pointer: +0 is the next-descriptor pointer, +4 is the control word, +8 is the buffer address. Control word bits: [31:16] byte count, [0] chain, [1] wait for command end, [2] wait for device ready, [3] direction (1 = memory to peripheral, 0 = peripheral to memory), [4] interrupt on completion.

Top module: `dma_cmd_seq`

## Requirements
- R1: A kick while idle reads the descriptor words at the start pointer, +4 and +8, in that order. Each request is held with a stable address until granted. A kick while not idle is ignored.
- R2: With direction 1, each peripheral request causes one memory read at the buffer address (rising by 4 each beat), held until granted. A one-cycle per_strobe follows, with per_wdata equal to the word read.
- R3: With direction 0, a peripheral request raises per_strobe and captures per_rdata in that cycle. The captured word is written to the buffer address with the request held until granted. No further beat starts until mem_done arrives.
- R4: debug_word[31:16] holds the memory-side bytes remaining and debug_word[15:0] the peripheral-side bytes remaining. Both load from the count when the control word is read, fall by 4 per beat on their own side, and are 0 after reset.
- R5: A descriptor with count 0 moves no data and goes straight to completion.
- R6: With the wait-for-command-end bit set, the channel does not go on after completion until per_cmd_end is seen.
- R7: With the wait-for-ready bit set, the channel then waits for dev_ready before it goes on.
- R8: After completion and the waits, chain bit 1 fetches the next descriptor from the stored next pointer. Chain bit 0 returns to idle, where no request is made.
- R9: Completion of a descriptor with bit 4 set gives a single-cycle irq pulse. No pulse is given when bit 4 is clear.
- R10: Terminate keeps a pending memory request asserted until it is granted (and a write until done), forwards no data, and then returns the channel to idle so that a new kick works.
- R11: With halt_on_term set, terminate parks the channel. Kicks are ignored and the counters hold. Only chan_rst (or rst) returns it to idle and clears the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_rst | input | 1 | Synchronous channel reset, same effect as rst |
| kick | input | 1 | Start descriptor processing when idle |
| start_ptr | input | ADDR_W | First descriptor address |
| halt_on_term | input | 1 | Park in halt after terminate |
| terminate | input | 1 | Stop the channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| mem_done | input | 1 | Granted write has completed |
| per_dreq | input | 1 | Peripheral data request |
| per_rdata | input | 32 | Data from peripheral |
| per_strobe | output | 1 | One peripheral beat taken or given |
| per_wdata | output | 32 | Data to peripheral |
| per_cmd_end | input | 1 | Peripheral command complete |
| dev_ready | input | 1 | External device ready |
| irq | output | 1 | Completion interrupt pulse |
| debug_word | output | 32 | Remaining bytes: memory side high, peripheral side low |

## Verification
The hardest case to reach is a terminate that arrives while a buffer read is still waiting for its grant. The channel has to keep requesting the same address, then drop the data and return to idle. The bench gets there by withholding grants for every address in the buffer region while still granting descriptor fetches. It pulses terminate while the buffer request is stalled, and releases the grant some cycles later. The wait states are reached the same way: the bench holds peripheral requests, command end and device ready low, watches for the absence of any memory request from the chained descriptor, and then releases each signal in turn.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_DREQ, ST_READ_REQ, ST_PER_PUSH,
    ST_WRITE_REQ, ST_WRITE_WAIT, ST_XFER_DONE, ST_WAIT_END,
    ST_WAIT_READY, ST_CHECK_CHAIN, ST_TERMINATE, ST_HALTED
  } seq_state_e;

  // control word flag positions
  localparam int CTL_CHAIN = 0;
  localparam int CTL_WEND  = 1;
  localparam int CTL_WRDY  = 2;
  localparam int CTL_M2P   = 3;
  localparam int CTL_IRQ   = 4;
  localparam int CTL_FLAGS = 5;

endpackage

// File: rtl/dma_seq_bytecnt.sv
module dma_seq_bytecnt #(
  parameter int CNT_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= (cnt < STEP_V) ? '0 : cnt - STEP_V;
  end

  AST_CNT_FALLS: assert property (@(posedge clk) disable iff (clr)
    (dec && !load && cnt != '0) |=> (cnt < $past(cnt))); // R4

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              kick,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic              halt_on_term,
  input  logic              terminate,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_done,
  input  logic              per_dreq,
  input  logic [31:0]       per_rdata,
  output logic              per_strobe,
  output logic [31:0]       per_wdata,
  input  logic              per_cmd_end,
  input  logic              dev_ready,
  input  logic [CNT_W-1:0]  mem_left,
  output logic              irq,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              dec_mem,
  output logic              dec_per
);

  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(STEP);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(STEP);

  seq_state_e               state;
  logic [1:0]               idx;
  logic [ADDR_W-1:0]        next_ptr, addr_q;
  logic [CTL_FLAGS-1:0]     flags;
  logic                     zero_cnt;
  logic [31:0]              data_q;
  logic                     t_req, t_we, t_done, irq_q;
  logic                     active, req_state;

  assign active    = !(state inside {ST_IDLE, ST_HALTED, ST_TERMINATE});
  assign req_state = state inside {ST_FETCH, ST_READ_REQ, ST_WRITE_REQ};

  assign mem_req    = req_state || (state == ST_TERMINATE && t_req);
  assign mem_we     = (state == ST_WRITE_REQ) || (state == ST_TERMINATE && t_req && t_we);
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign per_wdata  = data_q;
  assign per_strobe = (state == ST_PER_PUSH) ||
                      (state == ST_WAIT_DREQ && per_dreq && !flags[CTL_M2P] && !terminate);
  assign dec_per    = per_strobe;
  assign dec_mem    = !terminate && ((state == ST_READ_REQ && mem_gnt) ||
                                     (state == ST_WRITE_WAIT && mem_done));
  assign cnt_load   = !terminate && state == ST_FETCH && idx == 2'd1 && mem_gnt;
  assign cnt_val    = mem_rdata[31:16];
  assign irq        = irq_q;

  always_ff @(posedge clk) begin
    irq_q <= 1'b0;
    if (clr) begin
      state <= ST_IDLE;  idx <= '0;  addr_q <= '0;  next_ptr <= '0;
      flags <= '0;  zero_cnt <= 1'b0;  data_q <= '0;
      t_req <= 1'b0;  t_we <= 1'b0;  t_done <= 1'b0;
    end else if (terminate && active) begin
      state  <= ST_TERMINATE;
      t_req  <= req_state && !mem_gnt;
      t_we   <= (state == ST_WRITE_REQ);
      t_done <= (state == ST_WRITE_REQ && mem_gnt) || (state == ST_WRITE_WAIT && !mem_done);
    end else begin
      case (state)
        ST_IDLE: if (kick) begin
          state <= ST_FETCH;  addr_q <= start_ptr;  idx <= '0;
        end
        ST_FETCH: if (mem_gnt) begin
          if (idx == 2'd0) next_ptr <= mem_rdata[ADDR_W-1:0];
          if (idx == 2'd1) begin
            flags    <= mem_rdata[CTL_FLAGS-1:0];
            zero_cnt <= (mem_rdata[31:16] == 16'd0);
          end
          if (idx == 2'd2) begin
            addr_q <= mem_rdata[ADDR_W-1:0];
            idx    <= '0;
            state  <= zero_cnt ? ST_XFER_DONE : ST_WAIT_DREQ;
          end else begin
            idx    <= idx + 2'd1;
            addr_q <= addr_q + ASTEP;
          end
        end
        ST_WAIT_DREQ: if (per_dreq) begin
          if (flags[CTL_M2P]) state <= ST_READ_REQ;
          else begin
            data_q <= per_rdata;
            state  <= ST_WRITE_REQ;
          end
        end
        ST_READ_REQ: if (mem_gnt) begin
          data_q <= mem_rdata;
          addr_q <= addr_q + ASTEP;
          state  <= ST_PER_PUSH;
        end
        ST_PER_PUSH:   state <= (mem_left == '0) ? ST_XFER_DONE : ST_WAIT_DREQ;
        ST_WRITE_REQ:  if (mem_gnt) state <= ST_WRITE_WAIT;
        ST_WRITE_WAIT: if (mem_done) begin
          addr_q <= addr_q + ASTEP;
          state  <= (mem_left <= CSTEP) ? ST_XFER_DONE : ST_WAIT_DREQ;
        end
        ST_XFER_DONE: begin
          irq_q <= flags[CTL_IRQ];
          state <= flags[CTL_WEND] ? ST_WAIT_END :
                   flags[CTL_WRDY] ? ST_WAIT_READY : ST_CHECK_CHAIN;
        end
        ST_WAIT_END:   if (per_cmd_end) state <= flags[CTL_WRDY] ? ST_WAIT_READY : ST_CHECK_CHAIN;
        ST_WAIT_READY: if (dev_ready) state <= ST_CHECK_CHAIN;
        ST_CHECK_CHAIN: begin
          if (flags[CTL_CHAIN]) begin
            state <= ST_FETCH;  addr_q <= next_ptr;  idx <= '0;
          end else state <= ST_IDLE;
        end
        ST_TERMINATE: begin
          if (t_req) begin
            if (mem_gnt) begin
              t_req <= 1'b0;
              if (t_we) t_done <= 1'b1;
              else state <= halt_on_term ? ST_HALTED : ST_IDLE;
            end
          end else if (t_done) begin
            if (mem_done) begin
              t_done <= 1'b0;
              state  <= halt_on_term ? ST_HALTED : ST_IDLE;
            end
          end else state <= halt_on_term ? ST_HALTED : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (clr)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R1
  AST_WRITE_WAITS: assert property (@(posedge clk) disable iff (clr)
    (state == ST_WRITE_WAIT && !mem_done && !terminate) |=> (state == ST_WRITE_WAIT)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (clr)
    (state == ST_IDLE) |-> (!mem_req && !per_strobe)); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (clr)
    irq |=> !irq); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (clr)
    (state == ST_HALTED) |=> (state == ST_HALTED)); // R11

endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_rst,
  input  logic              kick,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic              halt_on_term,
  input  logic              terminate,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_done,
  input  logic              per_dreq,
  input  logic [31:0]       per_rdata,
  output logic              per_strobe,
  output logic [31:0]       per_wdata,
  input  logic              per_cmd_end,
  input  logic              dev_ready,
  output logic              irq,
  output logic [31:0]       debug_word
);

  localparam int CNT_W = 16;

  logic             clr, cnt_load, dec_mem, dec_per;
  logic [CNT_W-1:0] cnt_val, mem_left, per_left;

  assign clr        = rst || chan_rst;
  assign debug_word = {mem_left, per_left};

  dma_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP_BYTES)) u_ctrl (
    .clk(clk), .clr(clr), .kick(kick), .start_ptr(start_ptr),
    .halt_on_term(halt_on_term), .terminate(terminate),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .per_dreq(per_dreq), .per_rdata(per_rdata), .per_strobe(per_strobe),
    .per_wdata(per_wdata), .per_cmd_end(per_cmd_end), .dev_ready(dev_ready),
    .mem_left(mem_left), .irq(irq), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .dec_mem(dec_mem), .dec_per(dec_per)
  );

  dma_seq_bytecnt #(.CNT_W(CNT_W), .STEP(STEP_BYTES)) u_mem_cnt (
    .clk(clk), .clr(clr), .load(cnt_load), .load_val(cnt_val),
    .dec(dec_mem), .cnt(mem_left)
  );

  dma_seq_bytecnt #(.CNT_W(CNT_W), .STEP(STEP_BYTES)) u_per_cnt (
    .clk(clk), .clr(clr), .load(cnt_load), .load_val(cnt_val),
    .dec(dec_per), .cnt(per_left)
  );

endmodule

// File: tb/dma_cmd_seq_bench.sv
module dma_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1, chan_rst = 1'b0, kick = 1'b0, halt_on_term = 1'b0, terminate = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_done = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        per_dreq = 1'b0, per_strobe, per_cmd_end = 1'b0, dev_ready = 1'b0, irq;
  logic [31:0] per_rdata = 32'hA500_0000, per_wdata, debug_word;

  always #10 clk = ~clk;

  dma_cmd_seq u_dma_cmd_seq (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .kick(kick), .start_ptr(start_ptr),
    .halt_on_term(halt_on_term), .terminate(terminate),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .per_dreq(per_dreq), .per_rdata(per_rdata), .per_strobe(per_strobe),
    .per_wdata(per_wdata), .per_cmd_end(per_cmd_end), .dev_ready(dev_ready),
    .irq(irq), .debug_word(debug_word)
  );

  int tests = 0, fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] raq[$];   // expected read addresses
  logic [31:0] rdq[$];   // expected data to peripheral
  logic [63:0] wrq[$];   // expected {addr, data} writes
  bit  gnt_block = 0, done_pend = 0, cur_m2p = 1, upd_pend = 0, req_seen = 0;
  int  gwait = 0, done_cnt = 0, irq_cnt = 0, beats = 0, wbeats = 0, cycles = 0;

  function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // memory model, peripheral model and scoreboard monitor
  always @(negedge clk) begin
    mem_gnt  = 1'b0;
    mem_done = 1'b0;
    if (done_pend) begin
      if (done_cnt == 0) begin mem_done = 1'b1; done_pend = 0; end
      else done_cnt--;
    end
    if (upd_pend) begin per_rdata = 32'hA500_0000 + 32'(wbeats); upd_pend = 0; end
    if (mem_req) req_seen = 1;
    if (mem_req && !(gnt_block && mem_addr >= 32'h200)) begin
      if (gwait >= 1) begin
        mem_gnt = 1'b1;
        gwait   = 0;
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          done_pend = 1; done_cnt = 2;
          if (wrq.size() == 0) chk("R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
          else begin
            logic [63:0] e;
            e = wrq.pop_front();
            chk("R3 write addr", mem_addr, e[63:32]);
            chk("R3 write data", mem_wdata, e[31:0]);
          end
        end else begin
          mem_rdata = mem[mem_addr[9:2]];
          if (raq.size() == 0) chk("R1 unexpected read", mem_addr, 32'hFFFF_FFFF);
          else chk("R1 read addr order", mem_addr, raq.pop_front());
        end
      end else gwait++;
    end else gwait = 0;
    if (per_strobe) begin
      beats++;
      if (cur_m2p) begin
        if (rdq.size() == 0) chk("R2 unexpected beat", per_wdata, 32'hFFFF_FFFF);
        else chk("R2 peripheral data", per_wdata, rdq.pop_front());
      end else begin
        wbeats++;
        upd_pend = 1;
      end
    end
    if (irq) irq_cnt++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_kick(logic [31:0] p);
    start_ptr = p; kick = 1'b1; tick(1); kick = 1'b0;
  endtask

  task automatic wait_irq(int target, string req);
    int n = 0;
    while (irq_cnt < target && n < 500) begin tick(1); n++; end
    chk(req, 32'(irq_cnt), 32'(target));
  endtask

  task automatic push_fetch(logic [31:0] p);
    raq.push_back(p); raq.push_back(p + 4); raq.push_back(p + 8);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int base_irq, b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + 32'(i);
    // A: read 12 bytes, irq, no chain
    mem[8'h40] = 32'h0;  mem[8'h41] = 32'h000C_0018;  mem[8'h42] = 32'h200;
    // B: write 8 bytes, chain to C ; C: count 0, irq
    mem[8'h48] = 32'h130; mem[8'h49] = 32'h0008_0001; mem[8'h4A] = 32'h300;
    mem[8'h4C] = 32'h0;   mem[8'h4D] = 32'h0000_0010; mem[8'h4E] = 32'h0;
    // D: read 8, wait end + ready, irq, chain to 0x180 (count 0, irq)
    mem[8'h50] = 32'h180; mem[8'h51] = 32'h0008_001F; mem[8'h52] = 32'h240;
    mem[8'h60] = 32'h0;   mem[8'h61] = 32'h0000_0010; mem[8'h62] = 32'h0;
    // E and F: read 8, no flags
    mem[8'h54] = 32'h0;   mem[8'h55] = 32'h0008_0008; mem[8'h56] = 32'h250;
    mem[8'h58] = 32'h0;   mem[8'h59] = 32'h0008_0008; mem[8'h5A] = 32'h260;
    // Q: count 0, irq
    mem[8'h64] = 32'h0;   mem[8'h65] = 32'h0000_0010; mem[8'h66] = 32'h0;

    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R4 reset debug", debug_word, 32'h0);
    chk("R8 reset no request", {31'b0, mem_req}, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);

    // T1: memory to peripheral, three beats
    cur_m2p = 1; per_dreq = 1'b1;
    push_fetch(32'h100);
    for (int i = 0; i < 3; i++) begin
      raq.push_back(32'h200 + 32'(4*i));
      rdq.push_back(mem[8'h80 + 8'(i)]);
    end
    pulse_kick(32'h100);
    wait_irq(1, "R9 irq after read descriptor");
    tick(3);
    chk("R4 counters drained", debug_word, 32'h0);
    chk("R1 fetch queue drained", 32'(raq.size()), 0);
    chk("R2 data queue drained", 32'(rdq.size()), 0);
    req_seen = 0; tick(5);
    chk("R8 chain 0 stays idle", {31'b0, req_seen}, 32'h0);

    // T2: peripheral to memory, chained to zero-count descriptor
    cur_m2p = 0;
    push_fetch(32'h120); push_fetch(32'h130);
    wrq.push_back({32'h300, 32'hA500_0000 + 32'(wbeats)});
    wrq.push_back({32'h304, 32'hA500_0000 + 32'(wbeats + 1)});
    b0 = beats;
    pulse_kick(32'h120);
    wait_irq(2, "R9 only flagged descriptor pulses");
    tick(3);
    chk("R3 buffer word 0", mem[8'hC0], 32'hA500_0000 + 32'(wbeats - 2));
    chk("R3 write queue drained", 32'(wrq.size()), 0);
    chk("R5 zero count moves no data", 32'(beats - b0), 2);
    chk("R8 chain followed", 32'(raq.size()), 0);
    chk("R9 exact irq count", 32'(irq_cnt), 2);

    // T3: wait states, chained to 0x180
    cur_m2p = 1; per_dreq = 1'b0;
    push_fetch(32'h140);
    raq.push_back(32'h240); raq.push_back(32'h244);
    rdq.push_back(mem[8'h90]); rdq.push_back(mem[8'h91]);
    push_fetch(32'h180);
    base_irq = irq_cnt; b0 = beats;
    pulse_kick(32'h140);
    tick(12);
    chk("R4 loaded count", debug_word, 32'h0008_0008);
    per_dreq = 1'b1;
    begin
      int n = 0;
      while (beats == b0 && n < 200) begin tick(1); n++; end
    end
    per_dreq = 1'b0;
    tick(3);
    chk("R4 one beat taken", debug_word, 32'h0004_0004);
    per_dreq = 1'b1;
    tick(10);
    req_seen = 0; tick(5);
    chk("R6 held before command end", {31'b0, req_seen}, 32'h0);
    per_cmd_end = 1'b1; tick(1); per_cmd_end = 1'b0;
    tick(5);
    chk("R7 held before device ready", {31'b0, req_seen}, 32'h0);
    dev_ready = 1'b1;
    wait_irq(base_irq + 2, "R7 proceeds after ready");
    dev_ready = 1'b0;
    chk("R8 chained fetch done", 32'(raq.size()), 0);

    // T4: terminate with a stalled buffer read
    gnt_block = 1; per_dreq = 1'b1;
    push_fetch(32'h150); raq.push_back(32'h250);
    b0 = beats;
    pulse_kick(32'h150);
    begin
      int n = 0;
      while (!(mem_req && mem_addr == 32'h250) && n < 200) begin tick(1); n++; end
    end
    tick(2);
    terminate = 1'b1; tick(1); terminate = 1'b0;
    tick(5);
    chk("R10 request held", {31'b0, mem_req}, 32'h1);
    chk("R10 address held", mem_addr, 32'h250);
    gnt_block = 0;
    tick(4);
    chk("R10 request dropped", {31'b0, mem_req}, 32'h0);
    chk("R10 no data forwarded", 32'(beats - b0), 0);
    push_fetch(32'h190);
    base_irq = irq_cnt;
    pulse_kick(32'h190);
    wait_irq(base_irq + 1, "R10 kick works after terminate");

    // T5: halt on terminate
    halt_on_term = 1'b1; per_dreq = 1'b0;
    push_fetch(32'h160);
    pulse_kick(32'h160);
    tick(12);
    chk("R4 loaded before halt", debug_word, 32'h0008_0008);
    terminate = 1'b1; tick(1); terminate = 1'b0;
    tick(3);
    req_seen = 0;
    pulse_kick(32'h190);
    tick(10);
    chk("R11 kick ignored while halted", {31'b0, req_seen}, 32'h0);
    chk("R11 counters held while halted", debug_word, 32'h0008_0008);
    chan_rst = 1'b1; tick(1); chan_rst = 1'b0;
    tick(1);
    chk("R11 channel reset clears counters", debug_word, 32'h0);
    halt_on_term = 1'b0;
    push_fetch(32'h190);
    base_irq = irq_cnt;
    pulse_kick(32'h190);
    wait_irq(base_irq + 1, "R11 channel runs after reset");
    chk("R1 all reads matched", 32'(raq.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule